// File: doc/BRIEF.md
# Serial Sampling Converter Port and Power-Mode Controller

This block is the digital side of a serial sampling converter. It runs on the system clock and watches two slow external pins, an active-low chip-select and a serial clock. Both pins pass through two-flop synchronisers, and their edges are found in the system-clock domain. A falling chip-select opens a frame. At that moment the block captures the 14-bit result on its stub input, switches the track/hold strobe to hold, enables the serial data line and presents a leading zero. Each serial-clock falling edge then launches the next bit of a 16-bit word: a second zero, followed by the result from its most significant bit down. The line is released after the sixteenth falling edge. The strobe returns to track on the first rising edge that follows the fifteenth falling edge.

Chip-select also acts as the power-mode command. The block counts falling edges until chip-select rises, and that count selects the next mode. While powered, a rise after two to nine falling edges powers the block down. While powered down, a frame that runs past ten falling edges acts as a dummy wake-up frame. The data of a frame that began while powered down is flagged invalid. The tri-state output is modelled as a data bit plus an enable, and the pad is tri-stated whenever the enable is low.

Top module: `sadc_port`

## Requirements
- R1: After reset the data enable, hold strobe and data-valid flag are low, and the powered flag is high.
- R2: A chip-select falling edge raises the data enable and the hold strobe together.
- R3: The word is 16 bits, launched as bit 15 down to bit 0, with bits 15 and 14 zero and bits 13..0 the result. Bit 15 is presented at the chip-select fall, and bit 15-k after the k-th serial-clock falling edge. The result is captured at the chip-select fall, and later changes on the result input have no effect.
- R4: The data enable drops at the 16th falling edge. Further falling edges in the same frame change no output, because the counter saturates at 16.
- R5: Hold stays high through the 15th falling edge and drops at the next serial-clock rising edge.
- R6: A chip-select rise before the frame completes drops the data enable and the hold strobe.
- R7: While powered, a chip-select rise after 2 to 9 falling edges (boundaries included) clears the powered flag.
- R8: While powered, a chip-select rise after 0 or 1 falling edges, or after 10 or more, leaves the powered flag set.
- R9: While powered down, a rise after fewer than 10 falling edges keeps the flag clear. A rise after 10 or more sets it.
- R10: The data-valid flag is high during a frame that began while powered and low during a frame that began while powered down. It is low outside frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low chip-select pin, asynchronous |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| result_i | input | 14 | Conversion result from the converter stub |
| sdo_o | output | 1 | Serial data bit |
| sdo_en_o | output | 1 | Output enable for the serial data pad; low means high impedance |
| hold_o | output | 1 | Track/hold strobe, high means hold |
| powered_o | output | 1 | High while in normal (powered) mode |
| data_valid_o | output | 1 | Current frame carries valid data |

## Verification
Every cycle, the assertions check the relationships between outputs at the frame edges. The enable and the hold strobe open together with a zero on the line. The power flag changes only while the line is released and the strobe is in track. The data-valid flag rises only while powered and falls only when the frame closes. The bench's scenarios alone can show the bit order and the capture point of the result. They also cover the exact edge count at which the line releases and the strobe returns to track. The chip-select windows, including the 2, 9 and 10 boundaries, decide the next power mode. The invalid dummy frame and the valid frame that follows it are also checked there.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_t;

    typedef enum logic {
        PM_DOWN = 1'b0,
        PM_UP   = 1'b1
    } pmode_e;

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sadc_edge.sv
module sadc_edge
    import sadc_pkg::*;
#(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lvl,
    output edge_t ev
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d   = lvl;
        ev.level = lvl;
        ev.rise  = lvl & ~prev_q;
        ev.fall  = ~lvl & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RESET_VAL;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/sadc_frame.sv
module sadc_frame
    import sadc_pkg::*;
#(
    parameter int DATA_W     = 14,
    parameter int LEAD_ZEROS = 2,
    localparam int WORD_W    = DATA_W + LEAD_ZEROS,
    localparam int CNT_W     = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  edge_t             cs_n,
    input  edge_t             sck,
    input  logic [DATA_W-1:0] result,
    input  logic              powered,
    output logic              sdo,
    output logic              sdo_en,
    output logic              hold,
    output logic              frame_valid,
    output logic              end_pulse,
    output logic [CNT_W-1:0]  end_cnt
);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] TRACK_CNT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
        logic              en;
        logic              hold;
        logic              valid;
    } frame_t;

    frame_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (cs_n.fall) begin
                st_d.active = 1'b1;
                st_d.cnt    = '0;
                st_d.shreg  = {{LEAD_ZEROS{1'b0}}, result};
                st_d.en     = 1'b1;
                st_d.hold   = 1'b1;
                st_d.valid  = powered;
            end
        end else if (cs_n.rise) begin
            st_d.active = 1'b0;
            st_d.en     = 1'b0;
            st_d.hold   = 1'b0;
            st_d.valid  = 1'b0;
        end else begin
            if (sck.fall && st_q.cnt != LAST_CNT) begin
                st_d.cnt   = st_q.cnt + 1'b1;
                st_d.shreg = {st_q.shreg[WORD_W-2:0], 1'b0};
                if (st_q.cnt == TRACK_CNT) st_d.en = 1'b0;
            end
            if (sck.rise && st_q.cnt == TRACK_CNT) st_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo         = st_q.en & st_q.shreg[WORD_W-1];
    assign sdo_en      = st_q.en;
    assign hold        = st_q.hold;
    assign frame_valid = st_q.valid;
    assign end_pulse   = st_q.active & cs_n.rise;
    assign end_cnt     = st_q.cnt;
endmodule

// File: rtl/sadc_power.sv
module sadc_power
    import sadc_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int DOWN_FROM = 2,
    parameter int UP_AT     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             end_pulse,
    input  logic [CNT_W-1:0] end_cnt,
    output logic             powered
);
    localparam logic [CNT_W-1:0] LO = CNT_W'(DOWN_FROM);
    localparam logic [CNT_W-1:0] HI = CNT_W'(UP_AT);

    pmode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (end_pulse) begin
            if (mode_q == PM_UP) begin
                if (end_cnt >= LO && end_cnt < HI) mode_d = PM_DOWN;
            end else if (end_cnt >= HI) begin
                mode_d = PM_UP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= PM_UP;
        else        mode_q <= mode_d;
    end

    assign powered = (mode_q == PM_UP);
endmodule

// File: rtl/sadc_port.sv
module sadc_port
    import sadc_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int LEAD_ZEROS  = 2,
    parameter int SYNC_STAGES = 2,
    parameter int DOWN_FROM   = 2,
    parameter int UP_AT       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              sdo_o,
    output logic              sdo_en_o,
    output logic              hold_o,
    output logic              powered_o,
    output logic              data_valid_o
);
    localparam int WORD_W = DATA_W + LEAD_ZEROS;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int NPINS  = 2;

    logic [NPINS-1:0] pin_raw, pin_sync;
    edge_t            pin_ev [NPINS];

    assign pin_raw = {sclk_i, cs_n_i};

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        sadc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(pin_raw[i]), .q(pin_sync[i])
        );
        sadc_edge #(.RESET_VAL(1'b1)) u_edge (
            .clk(clk), .rst_n(rst_n), .lvl(pin_sync[i]), .ev(pin_ev[i])
        );
    end

    logic             end_pulse;
    logic [CNT_W-1:0] end_cnt;
    logic             powered;

    sadc_frame #(.DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .cs_n(pin_ev[0]), .sck(pin_ev[1]),
        .result(result_i), .powered(powered),
        .sdo(sdo_o), .sdo_en(sdo_en_o), .hold(hold_o),
        .frame_valid(data_valid_o),
        .end_pulse(end_pulse), .end_cnt(end_cnt)
    );

    sadc_power #(.CNT_W(CNT_W), .DOWN_FROM(DOWN_FROM), .UP_AT(UP_AT)) u_power (
        .clk(clk), .rst_n(rst_n),
        .end_pulse(end_pulse), .end_cnt(end_cnt),
        .powered(powered)
    );

    assign powered_o = powered;
endmodule

// File: rtl/sadc_port_chk.sv
module sadc_port_chk (
    input logic clk,
    input logic rst_n,
    input logic sdo_o,
    input logic sdo_en_o,
    input logic hold_o,
    input logic powered_o,
    input logic data_valid_o
);
    a_r2_open_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_en_o) |-> hold_o);

    a_r2_hold_opens_line: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> $rose(sdo_en_o));

    a_r3_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_en_o) |-> !sdo_o);

    a_r7_down_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(powered_o) |-> (!sdo_en_o && !hold_o));

    a_r9_up_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered_o) |-> (!sdo_en_o && !hold_o));

    a_r10_valid_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid_o) |-> (powered_o && sdo_en_o));

    a_r10_valid_ends_with_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_valid_o) |-> !hold_o);
endmodule

bind sadc_port sadc_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sdo_o(sdo_o), .sdo_en_o(sdo_en_o),
    .hold_o(hold_o), .powered_o(powered_o), .data_valid_o(data_valid_o)
);

// File: tb/sadc_port_test.sv
module sadc_port_test;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [13:0] result = '0;
    logic        sdo, sdo_en, hold, powered, dvalid;

    always #2 clk = ~clk;

    sadc_port uut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk),
        .result_i(result), .sdo_o(sdo), .sdo_en_o(sdo_en), .hold_o(hold),
        .powered_o(powered), .data_valid_o(dvalid)
    );

    typedef struct {
        string tag;
        int    sel;
        logic  exp;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    function automatic logic pick(int sel);
        case (sel)
            0: return sdo;
            1: return sdo_en;
            2: return hold;
            3: return powered;
            default: return dvalid;
        endcase
    endfunction

    // monitor: compares every queued expectation at the next falling clock edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic act;
                it = q.pop_front();
                act = pick(it.sel);
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d actual=%b expected=%b", it.tag, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic expect_v(int sel, logic v, string tag);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = v;
        q.push_back(it);
    endtask

    task automatic settle();
        repeat (HALF) @(posedge clk);
        #1;
    endtask

    // drive one frame: nfall serial-clock pulses, then release chip-select
    task automatic frame(logic [13:0] res, int nfall, bit exp_valid);
        logic [15:0] word;
        word = {2'b00, res};
        result = res;
        settle();
        cs_n = 1'b0;
        settle();
        expect_v(1, 1'b1, "R2 enable at open");
        expect_v(2, 1'b1, "R2 hold at open");
        expect_v(0, 1'b0, "R3 first zero");
        expect_v(4, exp_valid, "R10 valid flag in frame");
        result = ~res;
        for (int k = 1; k <= nfall; k++) begin
            sclk = 1'b0;
            settle();
            if (k < 16) begin
                expect_v(1, 1'b1, "R4 enable before 16th");
                expect_v(0, word[15-k], "R3 bit order");
                if (k == 15) expect_v(2, 1'b1, "R5 hold through 15th fall");
            end else begin
                expect_v(1, 1'b0, "R4 released at or after 16th");
                expect_v(2, 1'b0, "R4 hold stays track");
            end
            sclk = 1'b1;
            settle();
            if (k == 14) expect_v(2, 1'b1, "R5 hold after 14th rise");
            if (k == 15) expect_v(2, 1'b0, "R5 track after rise past 15th");
        end
        cs_n = 1'b1;
        settle();
        expect_v(1, 1'b0, "R6 enable off after cs rise");
        expect_v(2, 1'b0, "R6 hold off after cs rise");
        expect_v(4, 1'b0, "R10 valid low outside frame");
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();
        expect_v(1, 1'b0, "R1 reset enable");
        expect_v(2, 1'b0, "R1 reset hold");
        expect_v(3, 1'b1, "R1 reset powered");
        expect_v(4, 1'b0, "R1 reset valid");

        frame(14'h2A5C, 18, 1'b1);
        expect_v(3, 1'b1, "R8 full frame stays up");

        frame(14'h3FFF, 1, 1'b1);
        expect_v(3, 1'b1, "R8 rise after 1 edge stays up");

        frame(14'h1234, 12, 1'b1);
        expect_v(3, 1'b1, "R8 rise after 12 edges stays up");

        frame(14'h0001, 5, 1'b1);
        expect_v(3, 1'b0, "R7 rise after 5 edges powers down");

        frame(14'h0F0F, 9, 1'b0);
        expect_v(3, 1'b0, "R9 rise after 9 edges stays down");

        frame(14'h0AAA, 10, 1'b0);
        expect_v(3, 1'b1, "R9 rise after 10 edges wakes");

        frame(14'h3FFF, 16, 1'b1);
        expect_v(3, 1'b1, "R10 frame after wake valid");

        frame(14'h1555, 2, 1'b1);
        expect_v(3, 1'b0, "R7 rise after 2 edges powers down");

        frame(14'h2222, 16, 1'b0);
        expect_v(3, 1'b1, "R9 full dummy frame wakes");

        frame(14'h0000, 9, 1'b1);
        expect_v(3, 1'b0, "R7 rise after 9 edges powers down");

        repeat (4) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule